// File: doc/BRIEF.md
# Fully Associative Page Translation Cache

This block keeps a small set of recently used virtual-to-physical page translations close to the processor. A request carries a 32-bit virtual address and an access kind (read, write or instruction fetch). One cycle later the block answers with exactly one outcome: a hit with the physical address, a miss, a page fault or a protection fault. Pages are 4 KB, so the upper 20 address bits form the virtual page number and the lower 12 bits are the offset. Every stored translation is compared against the page number in the same cycle, and any translation may sit in any slot.

On a miss, a page walker or a software handler installs the translation through the refill port. A refill goes first to an empty slot and otherwise displaces the slot named by a rotating pointer. Each slot holds a frame number, a two-bit protection code, a present bit, and referenced and modified bits that the block maintains on successful accesses. A flush pulse, used when the running process changes, empties every slot at once. The slot count is a parameter, 64 by default.

Top module: `tlb_xlate`

## Requirements
- R1: `rsp_valid` is high in the cycle after `req_valid` was high and low otherwise; while it is high exactly one of `rsp_hit`, `rsp_miss`, `rsp_pgfault`, `rsp_protfault` is set, and while it is low all four are clear. After reset all response outputs are 0.
- R2: A lookup whose page number (address bits 31:12) equals no stored translation reports a miss.
- R3: A hit reports `rsp_paddr` as the slot's 20-bit frame number in bits 31:12 followed by the request's unchanged address bits 11:0.
- R4: A lookup that matches a slot whose present bit is 0 reports a page fault, whatever the protection code and access kind.
- R5: Access kind codes are 2'b00 read, 2'b01 write, 2'b10 fetch (2'b11 acts as read). Protection codes are 2'b00 no access, 2'b01 read-only, 2'b10 read/write, 2'b11 read/execute. A present slot reports a protection fault when the code is 2'b00, on a write unless the code is 2'b10, and on a fetch unless the code is 2'b11.
- R6: On a hit, `rsp_was_ref` and `rsp_was_mod` report the slot's referenced and modified bits as they stood before the access; every hit sets the referenced bit and a write hit also sets the modified bit; faults change neither; a refill starts both at 0.
- R7: A refill is visible to lookups from the cycle after it is presented; a lookup in the same cycle sees the previous contents.
- R8: A refill whose page number is already stored overwrites that slot and leaves every other slot and the rotating pointer unchanged.
- R9: A refill of a new page number goes to the lowest-numbered empty slot; when no slot is empty it goes to the slot named by the rotating pointer, which starts at 0 after reset and then advances by one, wrapping after the last slot.
- R10: A flush pulse empties every slot; a lookup in the same cycle reports a miss and a refill in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty all slots this cycle |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 32 | Virtual address of the lookup |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| fill_valid | input | 1 | Refill request present |
| fill_vpn | input | 20 | Page number to install |
| fill_pfn | input | 20 | Frame number to install |
| fill_prot | input | 2 | Protection code to install |
| fill_present | input | 1 | Present bit to install |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No stored translation matched |
| rsp_pgfault | output | 1 | Matched slot is not present |
| rsp_protfault | output | 1 | Access kind not allowed by protection |
| rsp_paddr | output | 32 | Physical address on a hit, else 0 |
| rsp_was_ref | output | 1 | Referenced bit before this hit |
| rsp_was_mod | output | 1 | Modified bit before this hit |

## Verification
The lookup can coincide with either a flush or a refill in the same cycle, and both pairings are driven on purpose. A flush together with a lookup of a stored page must give a miss, and a flush together with a refill must leave the refilled page absent on the following lookup. A refill presented together with a lookup of the same page must still miss, with the hit and its fresh referenced bit appearing only on the next lookup.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W  = 32;
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = 20;

    typedef enum logic [1:0] {
        ACC_RD  = 2'b00,
        ACC_WR  = 2'b01,
        ACC_FX  = 2'b10,
        ACC_RSV = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        PR_NONE = 2'b00,
        PR_RO   = 2'b01,
        PR_RW   = 2'b10,
        PR_RX   = 2'b11
    } prot_e;

    typedef struct packed {
        logic             held;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        prot_e            prot;
        logic             present;
        logic             ref_b;
        logic             mod_b;
    } slot_t;

    function automatic logic perm_ok(prot_e p, acc_e a);
        logic ok;
        case (a)
            ACC_WR:  ok = (p == PR_RW);
            ACC_FX:  ok = (p == PR_RX);
            default: ok = (p != PR_NONE);
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  slot_t             tab [ENTRIES],
    input  logic [VPN_W-1:0]  vpn,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);

    logic [ENTRIES-1:0] eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = tab[g].held && (tab[g].vpn == vpn);
    end

    always_comb begin
        hit = |eq;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  slot_t             tab [ENTRIES],
    input  logic [IDX_W-1:0]  rr,
    output logic [IDX_W-1:0]  slot,
    output logic              use_rr
);

    logic [ENTRIES-1:0] empty;
    logic [IDX_W-1:0]   first_empty;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_free
        assign empty[g] = ~tab[g].held;
    end

    always_comb begin
        first_empty = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (empty[i]) first_empty = IDX_W'(i);
        end
        use_rr = ~|empty;
        slot   = use_rr ? rr : first_empty;
    end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic        req_valid,
    input  logic [31:0] req_vaddr,
    input  logic [1:0]  req_acc,
    input  logic        fill_valid,
    input  logic [19:0] fill_vpn,
    input  logic [19:0] fill_pfn,
    input  logic [1:0]  fill_prot,
    input  logic        fill_present,
    output logic        rsp_valid,
    output logic        rsp_hit,
    output logic        rsp_miss,
    output logic        rsp_pgfault,
    output logic        rsp_protfault,
    output logic [31:0] rsp_paddr,
    output logic        rsp_was_ref,
    output logic        rsp_was_mod
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    typedef struct {
        slot_t             tab [ENTRIES];
        logic [IDX_W-1:0]  rr;
        logic              valid;
        logic              hit;
        logic              miss;
        logic              pgf;
        logic              prf;
        logic [VA_W-1:0]   paddr;
        logic              was_ref;
        logic              was_mod;
    } state_t;

    state_t d, q;

    slot_t            tab_q [ENTRIES];
    logic             lk_hit, fl_hit, use_rr;
    logic [IDX_W-1:0] lk_idx, fl_idx, victim;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) tab_q[i] = q.tab[i];
    end

    tlb_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) lookup_i (
        .tab (tab_q),
        .vpn (req_vaddr[VA_W-1:OFF_W]),
        .hit (lk_hit),
        .idx (lk_idx)
    );

    tlb_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) refill_i (
        .tab (tab_q),
        .vpn (fill_vpn),
        .hit (fl_hit),
        .idx (fl_idx)
    );

    tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) victim_i (
        .tab    (tab_q),
        .rr     (q.rr),
        .slot   (victim),
        .use_rr (use_rr)
    );

    always_comb begin
        slot_t            ent;
        logic [IDX_W-1:0] dst;
        acc_e             acc;

        d         = q;
        d.valid   = req_valid;
        d.hit     = 1'b0;
        d.miss    = 1'b0;
        d.pgf     = 1'b0;
        d.prf     = 1'b0;
        d.paddr   = '0;
        d.was_ref = 1'b0;
        d.was_mod = 1'b0;
        acc       = acc_e'(req_acc);
        ent       = q.tab[lk_idx];
        dst       = fl_hit ? fl_idx : victim;

        // lookup against the registered table
        if (req_valid) begin
            if (flush || !lk_hit) begin
                d.miss = 1'b1;
            end else if (!ent.present) begin
                d.pgf = 1'b1;
            end else if (!perm_ok(ent.prot, acc)) begin
                d.prf = 1'b1;
            end else begin
                d.hit                 = 1'b1;
                d.paddr               = {ent.pfn, req_vaddr[OFF_W-1:0]};
                d.was_ref             = ent.ref_b;
                d.was_mod             = ent.mod_b;
                d.tab[lk_idx].ref_b   = 1'b1;
                if (acc == ACC_WR) d.tab[lk_idx].mod_b = 1'b1;
            end
        end

        // flush beats refill; refill beats the lookup's bit update
        if (flush) begin
            for (int i = 0; i < ENTRIES; i++) d.tab[i].held = 1'b0;
        end else if (fill_valid) begin
            d.tab[dst].held    = 1'b1;
            d.tab[dst].vpn     = fill_vpn;
            d.tab[dst].pfn     = fill_pfn;
            d.tab[dst].prot    = prot_e'(fill_prot);
            d.tab[dst].present = fill_present;
            d.tab[dst].ref_b   = 1'b0;
            d.tab[dst].mod_b   = 1'b0;
            if (!fl_hit && use_rr) begin
                d.rr = (q.rr == LAST) ? '0 : q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) q.tab[i] <= '0;
            q.rr      <= '0;
            q.valid   <= 1'b0;
            q.hit     <= 1'b0;
            q.miss    <= 1'b0;
            q.pgf     <= 1'b0;
            q.prf     <= 1'b0;
            q.paddr   <= '0;
            q.was_ref <= 1'b0;
            q.was_mod <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rsp_valid     = q.valid;
    assign rsp_hit       = q.hit;
    assign rsp_miss      = q.miss;
    assign rsp_pgfault   = q.pgf;
    assign rsp_protfault = q.prf;
    assign rsp_paddr     = q.paddr;
    assign rsp_was_ref   = q.was_ref;
    assign rsp_was_mod   = q.was_mod;

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        flush,
    input logic        req_valid,
    input logic [31:0] req_vaddr,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic        rsp_miss,
    input logic        rsp_pgfault,
    input logic        rsp_protfault,
    input logic [31:0] rsp_paddr
);

    // R1
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R1
    resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R1
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_pgfault, rsp_protfault}) == 1));

    // R1
    quiet_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_pgfault || rsp_protfault));

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_hit || (rsp_paddr[11:0] == $past(req_vaddr[11:0]))));

    // R10
    flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && req_valid) |=> rsp_miss);

endmodule

bind tlb_xlate tlb_xlate_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_miss      (rsp_miss),
    .rsp_pgfault   (rsp_pgfault),
    .rsp_protfault (rsp_protfault),
    .rsp_paddr     (rsp_paddr)
);

// File: tb/tlb_xlate_tb_top.sv
module tlb_xlate_tb_top;

    localparam int N = 8;
    localparam logic [3:0] K_HIT = 4'b1000, K_MISS = 4'b0100,
                           K_PG  = 4'b0010, K_PR   = 4'b0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic [1:0]  fill_prot = '0;
    logic        fill_present = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_pgfault, rsp_protfault;
    logic [31:0] rsp_paddr;
    logic        rsp_was_ref, rsp_was_mod;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    tlb_xlate #(.ENTRIES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_acc(req_acc),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_prot(fill_prot), .fill_present(fill_present),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_pgfault(rsp_pgfault), .rsp_protfault(rsp_protfault),
        .rsp_paddr(rsp_paddr), .rsp_was_ref(rsp_was_ref), .rsp_was_mod(rsp_was_mod)
    );

    function automatic logic [3:0] kind();
        return {rsp_hit, rsp_miss, rsp_pgfault, rsp_protfault};
    endfunction

    function automatic logic allowed(logic [1:0] p, logic [1:0] a);
        if (p == 2'b00) return 1'b0;
        if (a == 2'b01) return p == 2'b10;
        if (a == 2'b10) return p == 2'b11;
        return 1'b1;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle: inputs set at a falling edge, response readable at the next one
    task automatic step(logic rq, logic [31:0] va, logic [1:0] acc, logic fl,
                        logic fv, logic [19:0] vpn, logic [19:0] pfn,
                        logic [1:0] prot, logic pres);
        req_valid = rq; req_vaddr = va; req_acc = acc; flush = fl;
        fill_valid = fv; fill_vpn = vpn; fill_pfn = pfn;
        fill_prot = prot; fill_present = pres;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; flush = 1'b0; fill_valid = 1'b0;
    endtask

    task automatic look(logic [31:0] va, logic [1:0] acc);
        step(1'b1, va, acc, 1'b0, 1'b0, '0, '0, '0, 1'b0);
    endtask

    task automatic fill(logic [19:0] vpn, logic [19:0] pfn, logic [1:0] prot, logic pres);
        step(1'b0, '0, '0, 1'b0, 1'b1, vpn, pfn, prot, pres);
    endtask

    task automatic expect_hit(string tag, logic [19:0] vpn, logic [19:0] pfn, logic [11:0] off);
        look({vpn, off}, 2'b00);
        chk({tag, " kind"}, kind(), K_HIT);
        chk({tag, " paddr"}, rsp_paddr, {pfn, off});
    endtask

    task automatic expect_miss(string tag, logic [19:0] vpn);
        look({vpn, 12'h5a5}, 2'b00);
        chk({tag, " kind"}, kind(), K_MISS);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        logic r_exp [N];
        logic m_exp [N];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 reset valid", rsp_valid, 1'b0);
        chk("R1 reset flags", kind(), 4'b0000);
        chk("R1 reset paddr", rsp_paddr, 32'h0);

        // R2 empty table
        expect_miss("R2 empty", 20'h00099);
        chk("R1 idle after request", rsp_valid, 1'b1);
        @(negedge clk);
        chk("R1 idle", rsp_valid, 1'b0);

        // load all slots: prot = i%4, slot 7 not present
        for (int i = 0; i < N; i++) begin
            fill(20'h00010 + 20'(i), 20'h80000 + 20'(i * 3), 2'(i % 4), i != 7);
            r_exp[i] = 1'b0;
            m_exp[i] = 1'b0;
        end

        // R3 R4 R5 R6 sweep: two passes over every slot and access kind
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < N; i++) begin
                for (int a = 0; a < 3; a++) begin
                    logic [11:0] off;
                    logic [19:0] pfn;
                    off = 12'(i * 273 + a * 17 + pass);
                    pfn = 20'h80000 + 20'(i * 3);
                    look({20'h00010 + 20'(i), off}, 2'(a));
                    chk("R1 valid", rsp_valid, 1'b1);
                    if (i == 7) begin
                        chk($sformatf("R4 slot%0d acc%0d", i, a), kind(), K_PG);
                    end else if (!allowed(2'(i % 4), 2'(a))) begin
                        chk($sformatf("R5 slot%0d acc%0d", i, a), kind(), K_PR);
                    end else begin
                        chk($sformatf("R5 hit slot%0d acc%0d", i, a), kind(), K_HIT);
                        chk($sformatf("R3 slot%0d acc%0d", i, a), rsp_paddr, {pfn, off});
                        chk($sformatf("R6 ref slot%0d acc%0d", i, a), rsp_was_ref, r_exp[i]);
                        chk($sformatf("R6 mod slot%0d acc%0d", i, a), rsp_was_mod, m_exp[i]);
                        r_exp[i] = 1'b1;
                        if (a == 1) m_exp[i] = 1'b1;
                    end
                end
            end
        end

        // R2 near tag
        expect_miss("R2 top bit differs", 20'h80010);

        // R10 flush with lookup of a stored page
        step(1'b1, {20'h00011, 12'h004}, 2'b00, 1'b1, 1'b0, '0, '0, '0, 1'b0);
        chk("R10 flush+lookup", kind(), K_MISS);
        expect_miss("R10 after flush", 20'h00011);

        // R10 flush with refill
        step(1'b0, '0, '0, 1'b1, 1'b1, 20'h00040, 20'h00777, 2'b10, 1'b1);
        expect_miss("R10 refill dropped", 20'h00040);

        // R7 refill with lookup of the same page
        step(1'b1, {20'h00041, 12'h3c0}, 2'b00, 1'b0, 1'b1, 20'h00041, 20'h12345, 2'b10, 1'b1);
        chk("R7 same-cycle miss", kind(), K_MISS);
        expect_hit("R7 next cycle", 20'h00041, 20'h12345, 12'h3c0);
        chk("R6 fresh ref", rsp_was_ref, 1'b0);

        // R9 / R8 replacement
        step(1'b0, '0, '0, 1'b1, 1'b0, '0, '0, '0, 1'b0);
        for (int i = 0; i < N; i++) fill(20'h00050 + 20'(i), 20'h00300 + 20'(i), 2'b10, 1'b1);
        expect_hit("R6 pre-overwrite", 20'h00053, 20'h00303, 12'h010);
        chk("R6 pre-overwrite ref", rsp_was_ref, 1'b0);
        fill(20'h00053, 20'habcde, 2'b10, 1'b1);
        expect_hit("R8 overwrite", 20'h00053, 20'habcde, 12'h020);
        chk("R6 refill clears ref", rsp_was_ref, 1'b0);
        for (int i = 0; i < N; i++) begin
            if (i != 3) expect_hit("R8 others kept", 20'h00050 + 20'(i), 20'h00300 + 20'(i), 12'h0f0);
        end

        fill(20'h00060, 20'h00600, 2'b10, 1'b1);
        expect_miss("R9 slot0 evicted", 20'h00050);
        expect_hit("R9 new in slot0", 20'h00060, 20'h00600, 12'h001);
        for (int i = 1; i < N; i++) begin
            logic [19:0] pf;
            pf = (i == 3) ? 20'habcde : 20'h00300 + 20'(i);
            expect_hit("R9 rest kept", 20'h00050 + 20'(i), pf, 12'h002);
        end
        fill(20'h00061, 20'h00601, 2'b10, 1'b1);
        expect_miss("R9 slot1 evicted", 20'h00051);
        expect_hit("R9 slot2 kept", 20'h00052, 20'h00302, 12'h003);
        expect_hit("R9 new in slot1", 20'h00061, 20'h00601, 12'h004);
        expect_hit("R9 slot0 kept", 20'h00060, 20'h00600, 12'h005);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule